// File: doc/BRIEF.md
# Sector Error-Recovery Sequencer

This block decides what happens to one disk sector whose first read failed its integrity check. It holds three configuration bytes: a policy byte, a retry limit and a correction span measured in 10-bit symbols. For each sector it receives a read status made of an error flag, a syndrome, a decoder verdict on whether the error can be fixed, and the number of symbols in error. From that status it runs a recovery sequence: rereads, an ECC correction, and finally one transfer of the sector, either corrected or raw. Along the way it may pulse an error-post output and a reallocation request.

The syndrome logic, the ECC decoder, the media path and the host transfer all sit outside the block. Each appears here only as a request/done handshake. A reread returns a fresh status together with its done pulse. The policy byte can reorder the sequence in several ways. It can skip recovery entirely. It can allow correction early, as soon as two matching syndromes arrive in a row. It can forbid correction while still posting the error. It can allow or suppress reallocation of hard errors.

Top module: `sector_recovery_seq`

## Requirements
- R1: After reset the policy is: read reallocation on, continuous off, early correction off, disable-correction off. The retry limit is 8 and the span is 32. With these defaults, a persistent error with 32 symbols is corrected after 8 rereads. The same error with 33 symbols is not corrected.
- R2: A write with `cfg_addr`=0 loads the policy byte. Its decoded bits are: bit 6 read reallocation, bit 4 continuous, bit 3 early correction, bit 0 disable correction. Bit 7 (write reallocation) and bit 2 (quiet) are accepted but change no behaviour here. `cfg_addr`=1 loads the retry limit and `cfg_addr`=2 loads the span. A write to `cfg_addr`=3 changes nothing.
- R3: A sector whose status shows no error goes straight to transfer with `xfer_raw`=0. There is no reread and no error post.
- R4: With continuous set, an errored sector is transferred at once with `xfer_raw`=1. There is no reread, no error post and no reallocation, whatever the other policy bits are.
- R5: With early correction clear, rereads come first. Each `rrd_req` is held until `rrd_done`. At most the retry limit of rereads is issued. If a reread returns no error, the sector is transferred with `xfer_raw`=0 and no post.
- R6: When the rereads are used up and the error remains, the block enters a hard-error cycle. In that cycle `err_post` pulses for one cycle, and `realloc_req` pulses with it if read reallocation is on. The error is correctable when the decoder flag is 1 and the symbol count is no greater than the span. A correctable error then gets one `cor_req`/`cor_done` handshake, followed by a transfer with `xfer_raw`=0.
- R7: An uncorrectable error is transferred with `xfer_raw`=1 after the rereads. The error is still posted.
- R8: With disable-correction set, a hard error is never corrected. It is transferred with `xfer_raw`=1 and the error is still posted.
- R9: With early correction set, the hard-error cycle starts as soon as a reread returns a nonzero syndrome equal to the one before it, provided the error is correctable. Zero syndromes, unequal syndromes and uncorrectable errors keep the reread sequence going.
- R10: A retry limit of 0 starts the hard-error cycle directly after the first failed read.
- R11: The block stays busy until `xfer_done` and each request stays high until its done. `sts_valid` has no effect while the block is busy.
- R12: With read reallocation clear, a hard error still pulses `err_post` but never `realloc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| sts_valid | input | 1 | First read status of a new sector (sampled in idle) |
| sts_err | input | 1 | Read showed an error |
| sts_syn | input | 16 | Error syndrome |
| sts_fixable | input | 1 | Decoder judges the error correctable |
| sts_nsym | input | 8 | Number of symbols in error |
| rrd_req | output | 1 | Reread request |
| rrd_done | input | 1 | Reread finished; status inputs valid |
| cor_req | output | 1 | ECC correction request |
| cor_done | input | 1 | Correction finished |
| xfer_req | output | 1 | Sector transfer request |
| xfer_raw | output | 1 | Transfer data without correction |
| xfer_done | input | 1 | Transfer finished |
| err_post | output | 1 | One-cycle error-post pulse |
| realloc_req | output | 1 | One-cycle reallocation pulse |
| busy | output | 1 | A sector is being handled |

## Verification
The assertions take four things for granted about the inputs. The configuration is written only while `busy` is low. Each done input pulses for one cycle, and only while its matching request is high. A reread's status is presented in the same cycle as `rrd_done`. The retry-bound and early-correction checks are valid only under those conditions. The bench keeps to them in three ways. Configuration writes are made only between sectors. The responder raises a done signal only after seeing the request at a falling edge, and drops it one cycle later. Every reread status is driven together with its done pulse.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REREAD,
    ST_HARD,
    ST_CORRECT,
    ST_XFER
  } srs_state_e;

  // policy byte bit positions
  localparam int POL_RD_REALLOC = 6;
  localparam int POL_CONT       = 4;
  localparam int POL_EARLY      = 3;
  localparam int POL_NOCORR     = 0;

  // configuration register select codes
  localparam logic [1:0] CFG_POLICY = 2'd0;
  localparam logic [1:0] CFG_RETRY  = 2'd1;
  localparam logic [1:0] CFG_SPAN   = 2'd2;

  localparam int RETRY_RST = 8;
  localparam int SPAN_RST  = 32;

  typedef struct packed {
    logic rd_realloc;
    logic cont;
    logic early;
    logic nocorr;
  } srs_policy_t;

  localparam srs_policy_t POLICY_RST = '{rd_realloc: 1'b1, cont: 1'b0, early: 1'b0, nocorr: 1'b0};

endpackage

// File: rtl/srs_cfg_regs.sv
module srs_cfg_regs
  import srs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output srs_policy_t       policy,
  output logic [DATA_W-1:0] retry_max,
  output logic [DATA_W-1:0] span
);

  srs_policy_t       pol_q, pol_d;
  logic [DATA_W-1:0] retry_q, retry_d;
  logic [DATA_W-1:0] span_q, span_d;

  always_comb begin
    pol_d   = pol_q;
    retry_d = retry_q;
    span_d  = span_q;
    if (cfg_we) begin
      case (cfg_addr)
        CFG_POLICY: begin
          pol_d.rd_realloc = cfg_wdata[POL_RD_REALLOC];
          pol_d.cont       = cfg_wdata[POL_CONT];
          pol_d.early      = cfg_wdata[POL_EARLY];
          pol_d.nocorr     = cfg_wdata[POL_NOCORR];
        end
        CFG_RETRY: retry_d = cfg_wdata;
        CFG_SPAN:  span_d  = cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= POLICY_RST;
      retry_q <= DATA_W'(RETRY_RST);
      span_q  <= DATA_W'(SPAN_RST);
    end else if (cfg_we) begin
      pol_q   <= pol_d;
      retry_q <= retry_d;
      span_q  <= span_d;
    end
  end

  assign policy    = pol_q;
  assign retry_max = retry_q;
  assign span      = span_q;

endmodule

// File: rtl/srs_read_track.sv
module srs_read_track #(
  parameter int DATA_W = 8,
  parameter int SYN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_evt,
  input  logic              rr_evt,
  input  logic [SYN_W-1:0]  syn_in,
  input  logic              fixable_in,
  input  logic [DATA_W-1:0] nsym_in,
  input  logic [DATA_W-1:0] retry_max,
  input  logic [DATA_W-1:0] span,
  output logic              more,
  output logic              early_hit,
  output logic              fix_now,
  output logic              fix_q
);

  localparam logic [DATA_W-1:0] CNT_TOP = '1;

  logic [DATA_W-1:0] cnt_q, cnt_d, cnt_inc, cnt_after;
  logic [SYN_W-1:0]  syn_q, syn_d;
  logic              vld_q, vld_d;
  logic              fixr_q, fixr_d;
  logic              evt;

  assign evt       = first_evt || rr_evt;
  assign cnt_inc   = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
  assign cnt_after = first_evt ? '0 : cnt_inc;
  assign more      = cnt_after < retry_max;
  assign fix_now   = fixable_in && (nsym_in <= span);
  assign early_hit = rr_evt && vld_q && (syn_in == syn_q) && (syn_in != '0);
  assign fix_q     = fixr_q;

  always_comb begin
    cnt_d  = cnt_q;
    syn_d  = syn_q;
    vld_d  = vld_q;
    fixr_d = fixr_q;
    if (evt) begin
      cnt_d  = cnt_after;
      syn_d  = syn_in;
      vld_d  = 1'b1;
      fixr_d = fix_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      syn_q  <= '0;
      vld_q  <= 1'b0;
      fixr_q <= 1'b0;
    end else if (evt) begin
      cnt_q  <= cnt_d;
      syn_q  <= syn_d;
      vld_q  <= vld_d;
      fixr_q <= fixr_d;
    end
  end

  // R5
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_evt |-> (cnt_q < retry_max));

endmodule

// File: rtl/srs_ctrl.sv
module srs_ctrl
  import srs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sts_valid,
  input  logic        sts_err,
  input  logic        rrd_done,
  input  logic        cor_done,
  input  logic        xfer_done,
  input  srs_policy_t policy,
  input  logic        more,
  input  logic        early_hit,
  input  logic        fix_now,
  input  logic        fix_q,
  output logic        first_evt,
  output logic        rr_evt,
  output logic        rrd_req,
  output logic        cor_req,
  output logic        xfer_req,
  output logic        xfer_raw,
  output logic        err_post,
  output logic        realloc_req,
  output logic        busy
);

  srs_state_e st_q, st_d;
  logic       raw_q, raw_d;

  assign first_evt = (st_q == ST_IDLE) && sts_valid;
  assign rr_evt    = (st_q == ST_REREAD) && rrd_done;

  always_comb begin
    st_d  = st_q;
    raw_d = raw_q;
    if (first_evt || rr_evt) begin
      if (!sts_err) begin
        st_d  = ST_XFER;
        raw_d = 1'b0;
      end else if (policy.cont) begin
        st_d  = ST_XFER;
        raw_d = 1'b1;
      end else if (policy.early && early_hit && fix_now) begin
        st_d = ST_HARD;
      end else if (more) begin
        st_d = ST_REREAD;
      end else begin
        st_d = ST_HARD;
      end
    end else begin
      case (st_q)
        ST_HARD: begin
          if (policy.nocorr || !fix_q) begin
            st_d  = ST_XFER;
            raw_d = 1'b1;
          end else begin
            st_d = ST_CORRECT;
          end
        end
        ST_CORRECT: if (cor_done) begin
          st_d  = ST_XFER;
          raw_d = 1'b0;
        end
        ST_XFER: if (xfer_done) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      raw_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      raw_q <= raw_d;
    end
  end

  assign rrd_req     = (st_q == ST_REREAD);
  assign cor_req     = (st_q == ST_CORRECT);
  assign xfer_req    = (st_q == ST_XFER);
  assign xfer_raw    = raw_q;
  assign err_post    = (st_q == ST_HARD);
  assign realloc_req = (st_q == ST_HARD) && policy.rd_realloc;
  assign busy        = (st_q != ST_IDLE);

  // R11
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> xfer_req);

  // R11
  rrd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rrd_req && !rrd_done) |=> rrd_req);

  // R6
  post_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_post |=> (!err_post && (cor_req || xfer_req)));

  // R3
  clean_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((first_evt || rr_evt) && !sts_err) |=> (xfer_req && !xfer_raw));

  // R4
  cont_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_evt && sts_err && policy.cont) |=> (xfer_req && xfer_raw && !err_post));

  // R8
  nocorr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_post && policy.nocorr) |=> (xfer_req && xfer_raw));

  // R9
  early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_evt && sts_err && !policy.cont && policy.early && early_hit && fix_now) |=> err_post);

endmodule

// File: rtl/sector_recovery_seq.sv
module sector_recovery_seq
  import srs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              sts_valid,
  input  logic              sts_err,
  input  logic [SYN_W-1:0]  sts_syn,
  input  logic              sts_fixable,
  input  logic [DATA_W-1:0] sts_nsym,
  output logic              rrd_req,
  input  logic              rrd_done,
  output logic              cor_req,
  input  logic              cor_done,
  output logic              xfer_req,
  output logic              xfer_raw,
  input  logic              xfer_done,
  output logic              err_post,
  output logic              realloc_req,
  output logic              busy
);

  srs_policy_t       policy;
  logic [DATA_W-1:0] retry_max, span;
  logic              first_evt, rr_evt, more, early_hit, fix_now, fix_q;

  srs_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .policy    (policy),
    .retry_max (retry_max),
    .span      (span)
  );

  srs_read_track #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_evt  (first_evt),
    .rr_evt     (rr_evt),
    .syn_in     (sts_syn),
    .fixable_in (sts_fixable),
    .nsym_in    (sts_nsym),
    .retry_max  (retry_max),
    .span       (span),
    .more       (more),
    .early_hit  (early_hit),
    .fix_now    (fix_now),
    .fix_q      (fix_q)
  );

  srs_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sts_valid   (sts_valid),
    .sts_err     (sts_err),
    .rrd_done    (rrd_done),
    .cor_done    (cor_done),
    .xfer_done   (xfer_done),
    .policy      (policy),
    .more        (more),
    .early_hit   (early_hit),
    .fix_now     (fix_now),
    .fix_q       (fix_q),
    .first_evt   (first_evt),
    .rr_evt      (rr_evt),
    .rrd_req     (rrd_req),
    .cor_req     (cor_req),
    .xfer_req    (xfer_req),
    .xfer_raw    (xfer_raw),
    .err_post    (err_post),
    .realloc_req (realloc_req),
    .busy        (busy)
  );

endmodule

// File: tb/sector_recovery_seq_test.sv
module sector_recovery_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        sts_valid, sts_err, sts_fixable;
  logic [15:0] sts_syn;
  logic [7:0]  sts_nsym;
  logic        rrd_req, rrd_done, cor_req, cor_done, xfer_req, xfer_raw, xfer_done;
  logic        err_post, realloc_req, busy;

  always #10 clk = ~clk;

  sector_recovery_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .sts_valid(sts_valid), .sts_err(sts_err), .sts_syn(sts_syn), .sts_fixable(sts_fixable),
    .sts_nsym(sts_nsym), .rrd_req(rrd_req), .rrd_done(rrd_done), .cor_req(cor_req),
    .cor_done(cor_done), .xfer_req(xfer_req), .xfer_raw(xfer_raw), .xfer_done(xfer_done),
    .err_post(err_post), .realloc_req(realloc_req), .busy(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;

  bit          rr_err  [16];
  logic [15:0] rr_syn  [16];
  bit          rr_fix  [16];
  logic [7:0]  rr_nsym [16];

  int g_rr, g_post, g_realloc, g_cor, g_xfer;
  bit g_raw, g_drop, g_idle_end;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fill(input bit e, input logic [15:0] s, input bit f, input logic [7:0] n);
    for (int i = 0; i < 16; i++) begin
      rr_err[i] = e; rr_syn[i] = s; rr_fix[i] = f; rr_nsym[i] = n;
    end
  endtask

  task automatic run_sector(input bit e, input logic [15:0] s, input bit f, input logic [7:0] n,
                            input int delay, input bit poke);
    int  wait_c = 0;
    int  idx    = 0;
    int  guard  = 0;
    bit  pend   = 1'b0;
    bit  fin    = 1'b0;
    g_rr = 0; g_post = 0; g_realloc = 0; g_cor = 0; g_xfer = 0;
    g_raw = 1'b0; g_drop = 1'b0;
    @(negedge clk);
    sts_valid = 1'b1; sts_err = e; sts_syn = s; sts_fixable = f; sts_nsym = n;
    @(negedge clk);
    while (!fin && guard < 2000) begin
      sts_valid = 1'b0; rrd_done = 1'b0; cor_done = 1'b0; xfer_done = 1'b0;
      if (err_post) g_post++;
      if (realloc_req) g_realloc++;
      if (pend && !(rrd_req || cor_req || xfer_req)) g_drop = 1'b1;
      if (rrd_req || cor_req || xfer_req) begin
        if (wait_c < delay) begin
          wait_c++;
          pend = 1'b1;
          if (poke) begin sts_valid = 1'b1; sts_err = 1'b0; end
        end else begin
          wait_c = 0;
          pend   = 1'b0;
          if (rrd_req) begin
            rrd_done = 1'b1;
            sts_err = rr_err[idx]; sts_syn = rr_syn[idx];
            sts_fixable = rr_fix[idx]; sts_nsym = rr_nsym[idx];
            idx = (idx < 15) ? idx + 1 : 15;
            g_rr++;
          end else if (cor_req) begin
            cor_done = 1'b1;
            g_cor++;
          end else begin
            xfer_done = 1'b1;
            g_raw = xfer_raw;
            g_xfer++;
            fin = 1'b1;
          end
        end
      end
      @(negedge clk);
      guard++;
    end
    sts_valid = 1'b0; rrd_done = 1'b0; cor_done = 1'b0; xfer_done = 1'b0;
    g_idle_end = !busy;
    if (!fin) chk("R11 sector never finished", 0, 1);
  endtask

  // expected outcome of one sector
  task automatic expect_out(input string tag, input int rr, input int post, input int realloc,
                            input int cor, input int raw);
    chk({tag, " rereads"}, g_rr, rr);
    chk({tag, " err_post"}, g_post, post);
    chk({tag, " realloc_req"}, g_realloc, realloc);
    chk({tag, " corrections"}, g_cor, cor);
    chk({tag, " xfer_raw"}, int'(g_raw), raw);
  endtask

  task automatic t_reset;
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset requests", int'({rrd_req, cor_req, xfer_req}), 0);
    chk("R6 reset pulses", int'({err_post, realloc_req}), 0);
  endtask

  task automatic t_defaults;
    fill(1'b1, 16'h0005, 1'b1, 8'd32);
    run_sector(1'b1, 16'h0005, 1'b1, 8'd32, 0, 1'b0);
    expect_out("R1 default span 32", 8, 1, 1, 1, 0);
    fill(1'b1, 16'h0005, 1'b1, 8'd33);
    run_sector(1'b1, 16'h0005, 1'b1, 8'd33, 0, 1'b0);
    expect_out("R1 R7 default span 33", 8, 1, 1, 0, 1);
  endtask

  task automatic t_clean;
    fill(1'b0, 16'h0000, 1'b1, 8'd0);
    run_sector(1'b0, 16'h0000, 1'b1, 8'd0, 0, 1'b0);
    expect_out("R3 clean read", 0, 0, 0, 0, 0);
    chk("R3 idle after transfer", int'(g_idle_end), 1);
  endtask

  task automatic t_recover;
    fill(1'b1, 16'h0011, 1'b1, 8'd2);
    rr_err[1] = 1'b0;
    run_sector(1'b1, 16'h0011, 1'b1, 8'd2, 0, 1'b0);
    expect_out("R5 reread recovers", 2, 0, 0, 0, 0);
  endtask

  task automatic t_retry_write;
    cfg_write(2'd1, 8'd3);
    fill(1'b1, 16'h0021, 1'b1, 8'd4);
    run_sector(1'b1, 16'h0021, 1'b1, 8'd4, 0, 1'b0);
    expect_out("R2 R6 retry limit 3", 3, 1, 1, 1, 0);
    cfg_write(2'd3, 8'd0);
    run_sector(1'b1, 16'h0021, 1'b1, 8'd4, 0, 1'b0);
    expect_out("R2 addr 3 ignored", 3, 1, 1, 1, 0);
  endtask

  task automatic t_span_write;
    cfg_write(2'd2, 8'd4);
    fill(1'b1, 16'h0031, 1'b1, 8'd5);
    run_sector(1'b1, 16'h0031, 1'b1, 8'd5, 0, 1'b0);
    expect_out("R2 R7 span 4 nsym 5", 3, 1, 1, 0, 1);
    fill(1'b1, 16'h0031, 1'b1, 8'd4);
    run_sector(1'b1, 16'h0031, 1'b1, 8'd4, 0, 1'b0);
    expect_out("R2 span 4 nsym 4", 3, 1, 1, 1, 0);
    fill(1'b1, 16'h0031, 1'b0, 8'd1);
    run_sector(1'b1, 16'h0031, 1'b0, 8'd1, 0, 1'b0);
    expect_out("R7 decoder flag clear", 3, 1, 1, 0, 1);
    cfg_write(2'd2, 8'd32);
  endtask

  task automatic t_cont;
    cfg_write(2'd0, 8'hD9);
    fill(1'b1, 16'h0041, 1'b1, 8'd1);
    run_sector(1'b1, 16'h0041, 1'b1, 8'd1, 0, 1'b0);
    expect_out("R4 continuous", 0, 0, 0, 0, 1);
  endtask

  task automatic t_nocorr;
    cfg_write(2'd0, 8'hC1);
    fill(1'b1, 16'h0051, 1'b1, 8'd1);
    run_sector(1'b1, 16'h0051, 1'b1, 8'd1, 0, 1'b0);
    expect_out("R8 disable correction", 3, 1, 1, 0, 1);
  endtask

  task automatic t_early;
    cfg_write(2'd0, 8'hC8);
    cfg_write(2'd1, 8'd8);
    fill(1'b1, 16'h0000, 1'b1, 8'd3);
    for (int i = 0; i < 16; i++) rr_syn[i] = 16'(i + 20);
    rr_syn[0] = 16'h0009; rr_syn[1] = 16'h0009;
    run_sector(1'b1, 16'h0007, 1'b1, 8'd3, 0, 1'b0);
    expect_out("R9 equal syndromes", 2, 1, 1, 1, 0);
    fill(1'b1, 16'h0000, 1'b1, 8'd3);
    run_sector(1'b1, 16'h0000, 1'b1, 8'd3, 0, 1'b0);
    expect_out("R9 zero syndromes", 8, 1, 1, 1, 0);
    fill(1'b1, 16'h0009, 1'b0, 8'd3);
    run_sector(1'b1, 16'h0009, 1'b0, 8'd3, 0, 1'b0);
    expect_out("R9 equal but uncorrectable", 8, 1, 1, 0, 1);
  endtask

  task automatic t_zero_retry;
    cfg_write(2'd0, 8'hC0);
    cfg_write(2'd1, 8'd0);
    fill(1'b1, 16'h0061, 1'b1, 8'd1);
    run_sector(1'b1, 16'h0061, 1'b1, 8'd1, 0, 1'b0);
    expect_out("R10 zero retries", 0, 1, 1, 1, 0);
  endtask

  task automatic t_no_realloc;
    cfg_write(2'd0, 8'h80);
    cfg_write(2'd1, 8'd2);
    fill(1'b1, 16'h0071, 1'b1, 8'd1);
    run_sector(1'b1, 16'h0071, 1'b1, 8'd1, 0, 1'b0);
    expect_out("R12 read realloc clear", 2, 1, 0, 1, 0);
    cfg_write(2'd0, 8'hC0);
  endtask

  task automatic t_handshake;
    fill(1'b1, 16'h0081, 1'b1, 8'd1);
    run_sector(1'b1, 16'h0081, 1'b1, 8'd1, 3, 1'b1);
    expect_out("R11 slow handshake", 2, 1, 1, 1, 0);
    chk("R11 request dropped early", int'(g_drop), 0);
    chk("R11 idle after xfer_done", int'(g_idle_end), 1);
    repeat (3) @(negedge clk);
    chk("R11 poke while busy ignored", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = 8'd0;
    sts_valid = 1'b0; sts_err = 1'b0; sts_syn = 16'd0; sts_fixable = 1'b0; sts_nsym = 8'd0;
    rrd_done = 1'b0; cor_done = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_defaults;
    t_clean;
    t_recover;
    t_retry_write;
    t_span_write;
    t_cont;
    t_nocorr;
    t_early;
    t_zero_retry;
    t_no_realloc;
    t_handshake;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule